// File: doc/BRIEF.md
# Byte-Accessed Up/Down Tick Counter

This block is a 16-bit counter that a processor reaches through an 8-bit register bus. The count has two byte locations. The low-byte location maps onto the counter directly. The high-byte location maps onto a single holding byte rather than onto the counter. Reading the low byte copies the counter's upper half into the holding byte in the same edge. Writing the low byte loads all sixteen bits at once: the upper half comes from the holding byte and the lower half comes from the bus. As a result, a read of low then high, or a write of high then low, always sees or sets one coherent 16-bit value while the counter is running.

The counter advances only in cycles where a tick enable from an outside clock-select stage is high. Each tick does exactly one thing: clear, add one or subtract one. Which one depends on a mode input and an internal direction bit. Three sequences are supported: a free-running wrap, a clear once the count matches a programmable limit, and a triangle between zero and the limit. Status outputs report when the count sits at its limit and when it sits at zero. An overflow event pulses for one cycle and also sets a sticky flag that the processor reads and clears. An external retrigger pulse forces the limit action at once.

Top module: `tick_counter16`

## Requirements
- R1: After a synchronous reset, the count, the holding byte and the read data are 0, the direction is up, and both the overflow flag and the overflow pulse are 0.
- R2: A read strobe at address 0 returns the low byte of the count on rdata one cycle later and copies the count's high byte into the holding byte. A read at address 1 returns the holding byte, even if the counter has moved since the low-byte read.
- R3: A write at address 1 changes only the holding byte and leaves the count untouched. A write at address 0 loads the count with {holding byte, wdata} in a single edge.
- R4: A write at address 0 takes priority over a tick and over a retrigger in the same cycle. Such a write produces no overflow pulse.
- R5: While tick_en and retrig are low and there is no write at address 0, the count and the direction hold their values.
- R6: Mode 0 (and mode 3, which behaves the same) counts up by one per tick and wraps from 0xFFFF to 0.
- R7: Mode 1 counts up by one per tick. On a tick where the count equals top_val, the count clears to 0.
- R8: Mode 2 counts up while the direction is up. A tick at a count at or above top_val turns the direction down and subtracts one. A tick at 0 while going down turns the direction up and adds one.
- R9: at_bottom is high exactly when the count is 0. at_top is high when the count equals the limit: 0xFFFF in modes 0 and 3, top_val in modes 1 and 2.
- R10: ovf_pulse is high for the one cycle that follows an edge where the count wrapped or cleared in modes 0, 1 or 3, or left 0 while going down in mode 2.
- R11: The overflow flag is bit 0 of address 2. It sets with every overflow pulse. A write at address 2 with wdata bit 0 high clears it, a write with bit 0 low has no effect, and a set in the same cycle wins over a clear.
- R12: A retrig pulse performs the limit action whether or not tick_en is high. In modes 0, 1 and 3 it clears the count to 0 and raises the overflow pulse. In mode 2 it turns the direction down and subtracts one, holding at 0, with no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable from the clock-select stage |
| mode | input | 2 | Counting sequence: 0/3 free, 1 clear on match, 2 up/down |
| top_val | input | 16 | Programmable limit for modes 1 and 2 |
| retrig | input | 1 | External event forcing the limit action |
| addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 status |
| wdata | input | 8 | Bus write data |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| rdata | output | 8 | Registered read data, valid the cycle after rd |
| at_top | output | 1 | Count equals the current limit |
| at_bottom | output | 1 | Count equals zero |
| ovf_pulse | output | 1 | One-cycle overflow request |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench reads a low byte and lets thirty-two ticks carry the count across a high-byte boundary before it reads the high byte. A design that routes the high location straight to the counter would return the advanced value there. It loads 16-bit values while ticks, and in one case a retrigger, hit the same edge as the low-byte write. A design that let counting win would show an off-by-one value or a spurious overflow. It walks the counter through the 0xFFFF wrap, the match clear and both turnarounds of the triangle, where an error in the comparison or the direction update shows up as a wrong count or a missing or extra pulse. It also tries clearing the flag in the same cycle as an overflow, where a design that got the priority wrong would lose the event.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;
  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_MATCH    = 2'd1,
    MODE_UPDN     = 2'd2,
    MODE_FREE_ALT = 2'd3
  } tc_mode_e;

  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } tc_dir_e;

  localparam logic [1:0] ADR_LO   = 2'd0;
  localparam logic [1:0] ADR_HI   = 2'd1;
  localparam logic [1:0] ADR_STAT = 2'd2;
endpackage

// File: rtl/tcnt_busif.sv
module tcnt_busif #(
  parameter int BW = 8,
  parameter int AW = 2,
  localparam int W = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  input  logic          rd,
  input  logic          wr,
  input  logic [W-1:0]  cnt,
  input  logic          flag,
  output logic [BW-1:0] rdata,
  output logic [BW-1:0] temp,
  output logic          ld_en,
  output logic [W-1:0]  ld_val,
  output logic          flag_clr
);
  import tcnt_pkg::*;

  logic sel_lo, sel_hi, sel_st;

  assign sel_lo   = (addr == AW'(ADR_LO));
  assign sel_hi   = (addr == AW'(ADR_HI));
  assign sel_st   = (addr == AW'(ADR_STAT));
  assign ld_en    = wr && sel_lo;
  assign ld_val   = {temp, wdata};
  assign flag_clr = wr && sel_st && wdata[0];

  // Holding byte: a high-byte write fills it, a low-byte read snapshots it
  always_ff @(posedge clk) begin
    if (rst) begin
      temp <= '0;
    end else if (wr && sel_hi) begin
      temp <= wdata;
    end else if (rd && sel_lo) begin
      temp <= cnt[W-1:BW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (sel_lo)      rdata <= cnt[BW-1:0];
      else if (sel_hi) rdata <= temp;
      else if (sel_st) rdata <= {{(BW-1){1'b0}}, flag};
      else             rdata <= '0;
    end
  end
endmodule

// File: rtl/tcnt_core.sv
module tcnt_core #(
  parameter int BW = 8,
  localparam int W = 2 * BW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  tcnt_pkg::tc_mode_e mode,
  input  logic [W-1:0]      top_val,
  input  logic              retrig,
  input  logic              ld_en,
  input  logic [W-1:0]      ld_val,
  output logic [W-1:0]      cnt,
  output logic              evt,
  output logic              at_top,
  output logic              at_bottom
);
  import tcnt_pkg::*;

  tc_dir_e      dir_q, dir_d;
  logic [W-1:0] cnt_d;
  logic [W-1:0] lim;
  logic         step;

  assign lim       = (mode == MODE_MATCH || mode == MODE_UPDN) ? top_val : '1;
  assign at_top    = (cnt == lim);
  assign at_bottom = (cnt == '0);
  assign step      = tick_en || retrig;

  always_comb begin
    cnt_d = cnt;
    dir_d = dir_q;
    evt   = 1'b0;
    if (ld_en) begin
      cnt_d = ld_val;
    end else if (step) begin
      unique case (mode)
        MODE_UPDN: begin
          if (retrig || (dir_q == DIR_UP && cnt >= top_val)) begin
            dir_d = DIR_DN;
            cnt_d = (cnt == '0) ? '0 : cnt - 1'b1;
          end else if (dir_q == DIR_DN && cnt == '0) begin
            dir_d = DIR_UP;
            cnt_d = cnt + 1'b1;
            evt   = 1'b1;
          end else if (dir_q == DIR_UP) begin
            cnt_d = cnt + 1'b1;
          end else begin
            cnt_d = cnt - 1'b1;
          end
        end
        MODE_MATCH: begin
          if (retrig || cnt == top_val) begin
            cnt_d = '0;
            evt   = 1'b1;
          end else begin
            cnt_d = cnt + 1'b1;
          end
        end
        default: begin
          if (retrig || cnt == '1) begin
            cnt_d = '0;
            evt   = 1'b1;
          end else begin
            cnt_d = cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt   <= cnt_d;
      dir_q <= dir_d;
    end
  end
endmodule

// File: rtl/tcnt_flag.sv
module tcnt_flag (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr,
  output logic pulse,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      flag  <= 1'b0;
    end else begin
      pulse <= evt;
      if (evt)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_counter16.sv
module tick_counter16 #(
  parameter int BW = 8,
  parameter int AW = 2,
  localparam int W = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic [1:0]    mode,
  input  logic [W-1:0]  top_val,
  input  logic          retrig,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  input  logic          rd,
  input  logic          wr,
  output logic [BW-1:0] rdata,
  output logic          at_top,
  output logic          at_bottom,
  output logic          ovf_pulse,
  output logic          ovf_flag
);
  import tcnt_pkg::*;

  logic [W-1:0]  cnt_q;
  logic [BW-1:0] temp_q;
  logic          ld_en;
  logic [W-1:0]  ld_val;
  logic          flag_clr;
  logic          evt;

  tcnt_busif #(.BW(BW), .AW(AW)) u_bus (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
    .cnt(cnt_q), .flag(ovf_flag), .rdata(rdata), .temp(temp_q),
    .ld_en(ld_en), .ld_val(ld_val), .flag_clr(flag_clr)
  );

  tcnt_core #(.BW(BW)) u_core (
    .clk(clk), .rst(rst), .tick_en(tick_en), .mode(tc_mode_e'(mode)),
    .top_val(top_val), .retrig(retrig), .ld_en(ld_en), .ld_val(ld_val),
    .cnt(cnt_q), .evt(evt), .at_top(at_top), .at_bottom(at_bottom)
  );

  tcnt_flag u_flag (
    .clk(clk), .rst(rst), .evt(evt), .clr(flag_clr),
    .pulse(ovf_pulse), .flag(ovf_flag)
  );
endmodule

// File: rtl/tick_counter16_chk.sv
module tick_counter16_chk #(
  parameter int BW = 8,
  parameter int AW = 2,
  localparam int W = 2 * BW
) (
  input logic          clk,
  input logic          rst,
  input logic          tick_en,
  input logic [1:0]    mode,
  input logic          retrig,
  input logic [AW-1:0] addr,
  input logic [BW-1:0] wdata,
  input logic          rd,
  input logic          wr,
  input logic [W-1:0]  cnt,
  input logic [BW-1:0] temp,
  input logic          ovf_pulse,
  input logic          ovf_flag,
  input logic          at_bottom
);
  logic ld;
  assign ld = wr && (addr == AW'(0));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !retrig && !ld) |=> $stable(cnt));

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt == {$past(temp), $past(wdata)}));

  p_snap_r2: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == AW'(0) && !(wr && addr == AW'(1))) |=> (temp == $past(cnt[W-1:BW])));

  p_free_r6: assert property (@(posedge clk) disable iff (rst)
    (tick_en && mode == 2'd0 && !retrig && !ld) |=> (cnt == W'($past(cnt) + 1'b1)));

  p_wrap_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf_pulse && $past(mode) != 2'd2) |-> at_bottom);

  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> ovf_flag);
endmodule

bind tick_counter16 tick_counter16_chk #(.BW(BW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .mode(mode), .retrig(retrig),
  .addr(addr), .wdata(wdata), .rd(rd), .wr(wr), .cnt(cnt_q), .temp(temp_q),
  .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag), .at_bottom(at_bottom)
);

// File: tb/test_tick_counter16.sv
`timescale 1ns/1ps
module test_tick_counter16;
  localparam logic [1:0] LO = 2'd0, HI = 2'd1, ST = 2'd2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] top_val = 16'hFFFF;
  logic        retrig = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'd0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  rdata;
  logic        at_top, at_bottom, ovf_pulse, ovf_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct { logic [7:0] val; string req; } exp_t;
  exp_t sb[$];
  logic rd_d = 1'b0;

  always #4 clk = ~clk;

  tick_counter16 i_tick_counter16 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .mode(mode), .top_val(top_val),
    .retrig(retrig), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
    .rdata(rdata), .at_top(at_top), .at_bottom(at_bottom),
    .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: read data is valid the cycle after the strobe
  always @(posedge clk) rd_d <= rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (sb.size() == 0) chk("scoreboard", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.req, rdata, e.val);
      end
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string req);
    @(negedge clk); addr = a; rd = 1'b1; sb.push_back('{e, req});
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic load16(input logic [15:0] v);
    bus_wr(HI, v[15:8]);
    bus_wr(LO, v[7:0]);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pulse_retrig();
    @(negedge clk); retrig = 1'b1;
    @(negedge clk); retrig = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 at_bottom", at_bottom, 1);
    chk("R1 at_top", at_top, 0);
    chk("R1 ovf_flag", ovf_flag, 0);
    chk("R1 ovf_pulse", ovf_pulse, 0);
    bus_rd(LO, 8'h00, "R1 low");
    bus_rd(HI, 8'h00, "R1 high");
    bus_rd(ST, 8'h00, "R1 status");

    // R5 hold with no tick, R3 atomic load and high-only write
    load16(16'h3456);
    repeat (10) @(negedge clk);
    bus_rd(LO, 8'h56, "R5 hold low");
    bus_rd(HI, 8'h34, "R3 load high");
    bus_wr(HI, 8'h77);
    bus_rd(LO, 8'h56, "R3 high write leaves low");
    bus_rd(HI, 8'h34, "R3 high write leaves count");

    // R4 write wins over ticks
    @(negedge clk); tick_en = 1'b1;
    bus_wr(HI, 8'hAB);
    bus_wr(LO, 8'hCD);
    tick_en = 1'b0;
    bus_rd(LO, 8'hCD, "R4 low under ticks");
    bus_rd(HI, 8'hAB, "R4 high under ticks");

    // R2 latched high byte while counter moves
    load16(16'h12F0);
    bus_rd(LO, 8'hF0, "R2 low");
    ticks(32);
    bus_rd(HI, 8'h12, "R2 latched high");
    bus_rd(LO, 8'h10, "R2 new low");
    bus_rd(HI, 8'h13, "R2 new high");

    // R6 / R9 / R10 / R11 free-run wrap
    load16(16'hFFFE);
    ticks(1);
    chk("R9 at_top", at_top, 1);
    chk("R9 not bottom", at_bottom, 0);
    chk("R10 no pulse early", ovf_pulse, 0);
    ticks(1);
    chk("R10 pulse on wrap", ovf_pulse, 1);
    chk("R9 at_bottom", at_bottom, 1);
    chk("R11 flag set", ovf_flag, 1);
    @(negedge clk);
    chk("R10 pulse one cycle", ovf_pulse, 0);
    bus_rd(LO, 8'h00, "R6 wrapped low");
    mode = 2'd3;
    load16(16'hFFFF);
    ticks(1);
    chk("R6 mode3 wrap pulse", ovf_pulse, 1);
    mode = 2'd0;
    bus_rd(ST, 8'h01, "R11 status set");
    bus_wr(ST, 8'h00);
    bus_rd(ST, 8'h01, "R11 write zero ignored");
    bus_wr(ST, 8'h01);
    chk("R11 cleared", ovf_flag, 0);
    bus_rd(ST, 8'h00, "R11 status cleared");
    load16(16'hFFFF);
    @(negedge clk); tick_en = 1'b1; addr = ST; wdata = 8'h01; wr = 1'b1;
    @(negedge clk); tick_en = 1'b0; wr = 1'b0;
    chk("R11 set wins", ovf_flag, 1);
    bus_wr(ST, 8'h01);

    // R7 clear on match
    mode = 2'd1; top_val = 16'd5;
    load16(16'h0000);
    ticks(5);
    chk("R7 at_top", at_top, 1);
    ticks(1);
    chk("R7 clear pulse", ovf_pulse, 1);
    chk("R7 at_bottom", at_bottom, 1);
    ticks(3);
    bus_rd(LO, 8'h03, "R7 restart");

    // R8 up/down
    mode = 2'd2; top_val = 16'd4;
    load16(16'h0000);
    ticks(6);
    bus_rd(LO, 8'h02, "R8 turn at top");
    ticks(2);
    chk("R8 at_bottom", at_bottom, 1);
    chk("R8 no pulse reaching zero", ovf_pulse, 0);
    ticks(1);
    chk("R10 pulse leaving bottom", ovf_pulse, 1);
    ticks(1);
    bus_rd(LO, 8'h02, "R8 up again");

    // R12 retrigger
    pulse_retrig();
    chk("R12 updn no pulse", ovf_pulse, 0);
    ticks(1);
    bus_rd(LO, 8'h00, "R12 updn turned down");
    mode = 2'd0;
    load16(16'h1234);
    pulse_retrig();
    chk("R12 free pulse", ovf_pulse, 1);
    bus_rd(LO, 8'h00, "R12 free low");
    bus_rd(HI, 8'h00, "R12 free high");
    mode = 2'd1; top_val = 16'd5;
    load16(16'h0003);
    pulse_retrig();
    bus_rd(LO, 8'h00, "R12 match clear");

    // R4 write wins over retrig and tick
    mode = 2'd0;
    bus_wr(HI, 8'h42);
    @(negedge clk); addr = LO; wdata = 8'h99; wr = 1'b1; retrig = 1'b1; tick_en = 1'b1;
    @(negedge clk); wr = 1'b0; retrig = 1'b0; tick_en = 1'b0;
    chk("R4 no pulse", ovf_pulse, 0);
    bus_rd(LO, 8'h99, "R4 retrig low");
    bus_rd(HI, 8'h42, "R4 retrig high");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) chk("scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule